// File: doc/BRIEF.md
# Dual-Port Pin Edge Interrupt Collector

This block watches two 32-pin input ports and turns selected pin transitions into interrupt requests. Each pin of each port carries two independent arm bits, one for a low-to-high transition and one for a high-to-low transition. A pin can therefore raise an event on rising edges only, on falling edges only, or on both. There is no level-sensitive mode.

The pins are first brought into the clock domain by a two-stage synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. An armed edge sets a sticky bit in that port's rise-pending or fall-pending register. The bit holds until a write-one-to-clear access removes it.

Each port exposes a summary bit that shows whether any of its pending bits is set. A single registered request line carries the OR of everything pending on both ports. Configuration and clearing go through one narrow write strobe that has a port select and a 2-bit operation code.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every arm register, every pending register, both summary bits and `irq` are 0.
- R2: A 0-to-1 transition on a pin whose rise arm bit is 1 sets that pin's bit in the rise-pending output three clock edges after the pin changes. The first two edges are the synchronizer and the third is the pending register.
- R3: A 1-to-0 transition on a pin whose fall arm bit is 1 sets that pin's bit in the fall-pending output with the same three-edge latency.
- R4: A pin with both arm bits set records each of its rising and falling transitions, each in its own pending register.
- R5: A transition on a pin whose matching arm bit is 0 leaves the pending registers unchanged.
- R6: A pending bit stays set until a clear write carries a 1 in that bit position. Clear-data bits that are 0 leave their pending bits untouched.
- R7: When a new armed edge and a clear of the same bit land on the same clock edge, the bit ends up set. Other bits cleared by that same write do go to 0.
- R8: `port_pend[p]` is 1 exactly when port p has any rise-pending or fall-pending bit set. Bit 0 is port 0 and bit 1 is port 1.
- R9: `irq` is a register that equals, one clock later, the OR of all pending bits of both ports.
- R10: A write happens on a clock edge where `wr_en` is 1. `wr_port` selects port 0 or port 1. `wr_kind` selects the operation: 0 loads the whole rise-arm register, 1 loads the whole fall-arm register, 2 clears rise-pending bits, 3 clears fall-pending bits. `wr_data` is the value loaded or the clear mask.
- R11: Pins, arm bits and writes of one port never change the pending bits of the other port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_p0 | input | 32 | Pin levels of port 0, asynchronous |
| pins_p1 | input | 32 | Pin levels of port 1, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_port | input | 1 | Port selected by the write |
| wr_kind | input | 2 | Operation code (see R10) |
| wr_data | input | 32 | Arm value or clear mask |
| rise_pend_p0 | output | 32 | Rise-pending bits of port 0 |
| fall_pend_p0 | output | 32 | Fall-pending bits of port 0 |
| rise_pend_p1 | output | 32 | Rise-pending bits of port 1 |
| fall_pend_p1 | output | 32 | Fall-pending bits of port 1 |
| port_pend | output | 2 | Per-port pending summary |
| irq | output | 1 | Shared registered interrupt request |

## Verification
A detected edge and a write-one-to-clear of the same pending bit can fall on the same clock edge. The bench provokes this by raising an armed pin that is already pending and then holding a clear strobe through the third clock edge after that change. The clear mask also covers a second pending bit that has no new edge. The scoreboard expects the colliding bit to remain set and the other bit to drop. Separately, the one-cycle lag of `irq` behind the summary is judged on both its rise and its fall.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic [1:0] {
        WK_RISE_ARM  = 2'd0,
        WK_FALL_ARM  = 2'd1,
        WK_CLR_RISE  = 2'd2,
        WK_CLR_FALL  = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise_hit,
    output logic [W-1:0] fall_hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    always_comb begin
        rise_hit = lvl & ~prev_q;
        fall_hit = ~lvl & prev_q;
    end
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] edge_hit,
    input  logic         arm_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend_q
);
    logic [W-1:0] arm_q;
    logic [W-1:0] clr_mask;
    logic [W-1:0] pend_d;

    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= '0;
        else if (arm_wr) arm_q <= wdata;
    end

    always_comb begin
        clr_mask = clr_wr ? wdata : '0;
        // a fresh armed edge overrides a clear of the same bit
        pend_d   = (pend_q & ~clr_mask) | (edge_hit & arm_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R6
    sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R5
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         sel,
    input  logic         wr_en,
    input  wr_kind_e     kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rise_pend,
    output logic [W-1:0] fall_pend,
    output logic         any_pend
);
    logic [W-1:0] lvl;
    logic [W-1:0] rise_hit;
    logic [W-1:0] fall_hit;
    logic         hit_wr;

    assign hit_wr = wr_en && sel;

    gpio_sync2 #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pins), .q_sync(lvl)
    );

    gpio_edge_det #(.W(W)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl),
        .rise_hit(rise_hit), .fall_hit(fall_hit)
    );

    gpio_pend_bank #(.W(W)) u_rise (
        .clk(clk), .rst_n(rst_n), .edge_hit(rise_hit),
        .arm_wr(hit_wr && kind == WK_RISE_ARM),
        .clr_wr(hit_wr && kind == WK_CLR_RISE),
        .wdata(wdata), .pend_q(rise_pend)
    );

    gpio_pend_bank #(.W(W)) u_fall (
        .clk(clk), .rst_n(rst_n), .edge_hit(fall_hit),
        .arm_wr(hit_wr && kind == WK_FALL_ARM),
        .clr_wr(hit_wr && kind == WK_CLR_FALL),
        .wdata(wdata), .pend_q(fall_pend)
    );

    assign any_pend = |{rise_pend, fall_pend};

    // R4
    no_dual_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((rise_pend & ~$past(rise_pend)) &
                   (fall_pend & ~$past(fall_pend))) == '0));

    // R11
    other_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel) |=> ((rise_pend & $past(rise_pend)) == $past(rise_pend)));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_p0,
    input  logic [WIDTH-1:0] pins_p1,
    input  logic             wr_en,
    input  logic             wr_port,
    input  logic [1:0]       wr_kind,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rise_pend_p0,
    output logic [WIDTH-1:0] fall_pend_p0,
    output logic [WIDTH-1:0] rise_pend_p1,
    output logic [WIDTH-1:0] fall_pend_p1,
    output logic [1:0]       port_pend,
    output logic             irq
);
    localparam int NPORTS = 2;

    logic [WIDTH-1:0] pins_a [NPORTS];
    logic [WIDTH-1:0] rise_a [NPORTS];
    logic [WIDTH-1:0] fall_a [NPORTS];
    wr_kind_e         kind;

    assign kind      = wr_kind_e'(wr_kind);
    assign pins_a[0] = pins_p0;
    assign pins_a[1] = pins_p1;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        gpio_edge_port #(.W(WIDTH)) u_port (
            .clk(clk), .rst_n(rst_n), .pins(pins_a[p]),
            .sel(wr_port == p[0]), .wr_en(wr_en), .kind(kind),
            .wdata(wr_data), .rise_pend(rise_a[p]),
            .fall_pend(fall_a[p]), .any_pend(port_pend[p])
        );
    end

    assign rise_pend_p0 = rise_a[0];
    assign fall_pend_p0 = fall_a[0];
    assign rise_pend_p1 = rise_a[1];
    assign fall_pend_p1 = fall_a[1];

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |port_pend;
    end

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|{rise_pend_p0, fall_pend_p0,
                                  rise_pend_p1, fall_pend_p1})));

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(port_pend != 2'b00));
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins_p0 = '0;
    logic [31:0] pins_p1 = '0;
    logic        wr_en = 1'b0;
    logic        wr_port = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rise_pend_p0, fall_pend_p0, rise_pend_p1, fall_pend_p1;
    logic [1:0]  port_pend;
    logic        irq;

    always #5 clk = ~clk;

    gpio_edge_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pins_p0(pins_p0), .pins_p1(pins_p1),
        .wr_en(wr_en), .wr_port(wr_port), .wr_kind(wr_kind), .wr_data(wr_data),
        .rise_pend_p0(rise_pend_p0), .fall_pend_p0(fall_pend_p0),
        .rise_pend_p1(rise_pend_p1), .fall_pend_p1(fall_pend_p1),
        .port_pend(port_pend), .irq(irq)
    );

    typedef struct {
        int          req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return rise_pend_p0;
            1: return fall_pend_p0;
            2: return rise_pend_p1;
            3: return fall_pend_p1;
            4: return {30'b0, port_pend};
            default: return {31'b0, irq};
        endcase
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = observe(it.sel);
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL R%0d sel=%0d actual=%h expected=%h",
                             it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic push(int req, int sel, logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic port, logic [1:0] kind, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_port = port; wr_kind = kind; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_up();
        repeat (2) @(negedge clk);
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        for (int s = 0; s < 6; s++) push(1, s, 32'h0);

        // R10 arm rise on port 0 bits 0 and 5
        wr(1'b0, 2'd0, 32'h0000_0021);
        // R2 latency of a rising edge
        @(negedge clk); pins_p0[0] = 1'b1;
        cyc(2); push(2, 0, 32'h0); push(9, 5, 32'h0);
        cyc(1); push(2, 0, 32'h1); push(8, 4, 32'h1); push(9, 5, 32'h0);
        cyc(1); push(9, 5, 32'h1);

        // R5 unarmed pin 1 rise is ignored
        @(negedge clk); pins_p0[1] = 1'b1;
        cyc(5); push(5, 0, 32'h1); push(5, 1, 32'h0);

        // R3 fall arm on bits 0 and 5, drop pin 0
        wr(1'b0, 2'd1, 32'h0000_0021);
        @(negedge clk); pins_p0[0] = 1'b0;
        cyc(2); push(3, 1, 32'h0);
        cyc(1); push(3, 1, 32'h1);

        // R4 both edges of pin 5
        @(negedge clk); pins_p0[5] = 1'b1;
        cyc(4);
        @(negedge clk); pins_p0[5] = 1'b0;
        cyc(4); push(4, 0, 32'h21); push(4, 1, 32'h21);

        // R6 clearing with mask 0x20 keeps bit 0
        wr(1'b0, 2'd2, 32'h0000_0020);
        cyc(0); push(6, 0, 32'h1);
        wr(1'b0, 2'd2, 32'h0000_0001);
        cyc(0); push(6, 0, 32'h0); push(6, 1, 32'h21);

        // R7 set bits 0 and 5, then collide a new rise of bit 5 with a clear
        @(negedge clk); pins_p0[0] = 1'b1; pins_p0[5] = 1'b1;
        cyc(4); push(7, 0, 32'h21);
        @(negedge clk); pins_p0[5] = 1'b0;
        cyc(4);
        @(negedge clk); pins_p0[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_port = 1'b0; wr_kind = 2'd2; wr_data = 32'h21;
        @(negedge clk);
        wr_en = 1'b0;
        cyc(0); push(7, 0, 32'h20);

        // R11 port 1 fall on bit 31, port 0 untouched
        wr(1'b1, 2'd1, 32'h8000_0000);
        @(negedge clk); pins_p1[31] = 1'b1;
        cyc(4);
        @(negedge clk); pins_p1[31] = 1'b0;
        cyc(4);
        push(11, 3, 32'h8000_0000); push(11, 2, 32'h0);
        push(11, 0, 32'h20); push(8, 4, 32'h3);

        // R9 clear port 0 fully, then port 1; irq lags one cycle
        wr(1'b0, 2'd2, 32'hFFFF_FFFF);
        wr(1'b0, 2'd3, 32'hFFFF_FFFF);
        cyc(0); push(8, 4, 32'h2); push(9, 5, 32'h1);
        @(negedge clk);
        wr_en = 1'b1; wr_port = 1'b1; wr_kind = 2'd3; wr_data = 32'hFFFF_FFFF;
        cyc(1); push(8, 4, 32'h0); push(9, 5, 32'h1);
        @(negedge clk); wr_en = 1'b0;
        cyc(0); push(9, 5, 32'h0);

        done = 1'b1;
        finish_up();
    end
endmodule